// File: doc/BRIEF.md
# Constant-Time Byte String Comparator

This block decides whether a byte string arriving on a valid/ready stream equals a reference string held inside the block. Differences are folded into an accumulator by XOR-ing each candidate byte with the reference byte at the same position and OR-ing the result in. The stream is never stalled and never cut short. A result therefore appears after a number of cycles set only by how many beats were sent. The position of the first difference has no effect on it, and neither has the content of either string.

The reference bytes are written one at a time through a small write port, and the reference length is set through a companion length write. A comparison ends with the beat that carries the last marker. A terminating beat may carry no payload byte, so an empty candidate can be expressed. One cycle after that beat, the block gives a one-cycle result pulse. The pulse carries a match flag and a length-error flag. The internal counter and accumulator are cleared on that same edge, ready for the next string.

Top module: `ct_stream_cmp`

## Requirements
- R1: While `rst_n` is low, `s_ready` and `res_valid` are 0; from the first clock edge after reset release, `s_ready` is 1.
- R2: After reset, `s_ready` stays 1 on every cycle, so each beat takes exactly one cycle whatever its content.
- R3: `res_valid` is high for exactly the one cycle that follows the clock edge that accepts a beat with `s_last`=1. Outside that pulse, `res_match` and `res_len_err` are 0.
- R4: `res_match` is 1 only when the number of payload bytes equals the reference length and every byte equals the reference byte at the same index (index 0 is the first byte sent).
- R5: A single differing byte at any position, including the first and the last, gives `res_match`=0.
- R6: When the payload byte count differs from the reference length, `res_len_err`=1 and `res_match`=0. This applies to strings that are too short and to strings that are too long.
- R7: A comparison made of one beat with `s_empty`=1 and `s_last`=1 has zero payload bytes and is reported with `res_len_err`=1 and `res_match`=0.
- R8: Bytes beyond the reference length are still accepted at one per cycle, and no result is produced before the last-marked beat.
- R9: The byte counter and the accumulator clear with every result, so each comparison is independent of the one before it.
- R10: `ref_we` writes `ref_wdata` to reference index `ref_addr`. `len_we` loads `len_wdata` as the reference length only when it lies in 1..MAX_LEN (default 64); any other value is ignored and the previous length is kept. After reset the length is 1 and all reference bytes are 0.
- R11: For candidates with the same number of beats, the number of cycles from the first beat to the result is the same whether they differ at the first byte, at the last byte, or not at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_we | input | 1 | Reference byte write strobe |
| ref_addr | input | 6 | Reference byte index, $clog2(MAX_LEN) bits |
| ref_wdata | input | 8 | Reference byte value |
| len_we | input | 1 | Reference length write strobe |
| len_wdata | input | 7 | Reference length, accepted in 1..MAX_LEN |
| s_valid | input | 1 | Candidate beat valid |
| s_ready | output | 1 | Candidate beat ready |
| s_data | input | 8 | Candidate byte |
| s_last | input | 1 | Beat closes the candidate string |
| s_empty | input | 1 | Beat carries no payload byte |
| res_valid | output | 1 | One-cycle result pulse |
| res_match | output | 1 | Candidate equals reference |
| res_len_err | output | 1 | Candidate byte count differs from reference length |

## Verification
The assertions take for granted that the reference is not rewritten while a candidate is in flight. They also assume that `s_empty` is raised only on a beat that is both first and last. The bench loads the reference only between comparisons, with the stream idle, and uses `s_empty` only for the single-beat empty case. Within those limits, constrained random strings of random length are mixed with directed cases: differences at the first and last positions, short and long strings, the empty string, rejected length writes, and the length extremes 1 and 64. For each case the bench compares the flags and the cycle count to the result against its own model.

// File: rtl/ct_cmp_pkg.sv
// Package: shared byte type and width for the constant-time comparator.
// Assumes byte-wide candidate and reference data.
package ct_cmp_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ct_ref_store.sv
// Reference store: register array of MAX_LEN bytes plus a length register.
// Writes are single-cycle; a length outside 1..MAX_LEN is ignored.
// Assumes the owner does not write while a comparison is in flight.
module ct_ref_store
    import ct_cmp_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int ADDR_W  = $clog2(MAX_LEN),
    parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_byte,
    input  logic              len_wr_en,
    input  logic [LEN_W-1:0]  len_wr_val,
    input  logic [ADDR_W-1:0] rd_idx,
    output byte_t             rd_byte,
    output logic [LEN_W-1:0]  len_q
);
    byte_t mem_q [MAX_LEN];

    // One register per reference byte, written when its index is addressed.
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                mem_q[i] <= wr_byte;
        end
    end

    // Length register: accepts only lengths the array can hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= LEN_W'(1);
        else if (len_wr_en && len_wr_val >= LEN_W'(1) && len_wr_val <= LEN_W'(MAX_LEN))
            len_q <= len_wr_val;
    end

    // Read port: plain index into the array, no data-dependent path.
    always_comb rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/ct_diff_acc.sv
// Difference accumulator: ORs the XOR of each candidate/reference byte pair
// into an accumulator and counts payload bytes (saturating at CNT_MAX).
// On a last-marked beat it registers the result and clears its state.
// Assumes at most one beat per cycle, flagged by 'beat'.
module ct_diff_acc
    import ct_cmp_pkg::*;
#(
    parameter int LEN_W   = 7,
    parameter int CNT_MAX = 65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             has_byte,
    input  logic             is_last,
    input  byte_t            cand_byte,
    input  byte_t            ref_byte,
    input  logic [LEN_W-1:0] ref_len,
    output logic [LEN_W-1:0] cnt_q,
    output logic             res_valid,
    output logic             res_match,
    output logic             res_len_err
);
    byte_t            acc_q;
    byte_t            acc_nxt;
    logic [LEN_W-1:0] cnt_nxt;
    logic             take;

    // Next-state values of the accumulator and the byte counter.
    always_comb begin
        take    = beat && has_byte;
        acc_nxt = take ? (acc_q | (cand_byte ^ ref_byte)) : acc_q;
        cnt_nxt = cnt_q;
        if (take && cnt_q != LEN_W'(CNT_MAX))
            cnt_nxt = cnt_q + LEN_W'(1);
    end

    // State update: accumulate on each beat, clear when the string closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (beat && is_last) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // Result register: one-cycle pulse, flags zero outside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_match   <= 1'b0;
            res_len_err <= 1'b0;
        end else if (beat && is_last) begin
            res_valid   <= 1'b1;
            res_match   <= (acc_nxt == '0) && (cnt_nxt == ref_len);
            res_len_err <= (cnt_nxt != ref_len);
        end else begin
            res_valid   <= 1'b0;
            res_match   <= 1'b0;
            res_len_err <= 1'b0;
        end
    end
endmodule

// File: rtl/ct_stream_cmp.sv
// Top: constant-time comparison of a streamed byte string with a stored
// reference. The stream is always ready after reset, so latency depends only
// on the beat count. Assumes the reference is stable during a comparison and
// that s_empty is used only on a single beat that is also last.
module ct_stream_cmp
    import ct_cmp_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int ADDR_W = $clog2(MAX_LEN),
    localparam int LEN_W  = $clog2(MAX_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_we,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [7:0]        ref_wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_empty,
    output logic              res_valid,
    output logic              res_match,
    output logic              res_len_err
);
    logic              ready_q;
    logic              beat;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_cur;
    logic [ADDR_W-1:0] rd_idx;
    byte_t             ref_byte;

    // Ready register: low in reset, high for ever after.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Handshake and reference index; overlong bytes read index 0 harmlessly.
    always_comb begin
        s_ready = ready_q;
        beat    = s_valid && ready_q;
        rd_idx  = (cnt < LEN_W'(MAX_LEN)) ? cnt[ADDR_W-1:0] : '0;
    end

    ct_ref_store #(
        .MAX_LEN (MAX_LEN),
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ref_we),
        .wr_addr    (ref_addr),
        .wr_byte    (ref_wdata),
        .len_wr_en  (len_we),
        .len_wr_val (len_wdata),
        .rd_idx     (rd_idx),
        .rd_byte    (ref_byte),
        .len_q      (len_cur)
    );

    ct_diff_acc #(
        .LEN_W   (LEN_W),
        .CNT_MAX (MAX_LEN + 1)
    ) acc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat),
        .has_byte    (!s_empty),
        .is_last     (s_last),
        .cand_byte   (s_data),
        .ref_byte    (ref_byte),
        .ref_len     (len_cur),
        .cnt_q       (cnt),
        .res_valid   (res_valid),
        .res_match   (res_match),
        .res_len_err (res_len_err)
    );
endmodule

// File: rtl/ct_stream_cmp_chk.sv
// Checker bound to ct_stream_cmp: port-level timing and flag consistency.
// Assumes synchronous active-low reset held for at least one edge.
module ct_stream_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic s_valid,
    input logic s_ready,
    input logic s_last,
    input logic res_valid,
    input logic res_match,
    input logic res_len_err
);
    logic out_of_reset_q;

    // Marks cycles after the first edge seen out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_of_reset_q <= 1'b0;
        else        out_of_reset_q <= 1'b1;
    end

    a_r2_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_reset_q |-> s_ready);

    a_r3_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> res_valid);

    a_r3_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(s_valid && s_ready && s_last));

    a_r3_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_match && !res_len_err));

    a_r6_len_err_blocks_match: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_len_err) |-> !res_match);
endmodule

bind ct_stream_cmp ct_stream_cmp_chk chk_i (.*);

// File: tb/ct_stream_cmp_tb_top.sv
`timescale 1ns/1ps
module ct_stream_cmp_tb_top;
    localparam int MAX_LEN = 64;
    localparam int ADDR_W  = $clog2(MAX_LEN);
    localparam int LEN_W   = $clog2(MAX_LEN + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_we = 1'b0;
    logic [ADDR_W-1:0] ref_addr = '0;
    logic [7:0] ref_wdata = '0;
    logic len_we = 1'b0;
    logic [LEN_W-1:0] len_wdata = '0;
    logic s_valid = 1'b0;
    logic s_ready;
    logic [7:0] s_data = '0;
    logic s_last = 1'b0;
    logic s_empty = 1'b0;
    logic res_valid, res_match, res_len_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] ref_m [MAX_LEN];
    int         ref_len_m = 1;
    logic [7:0] cand [MAX_LEN + 16];

    always #2.5 clk = ~clk;

    ct_stream_cmp #(.MAX_LEN(MAX_LEN)) dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_match(input int n);
        if (n != ref_len_m) return 1'b0;
        for (int i = 0; i < n; i++)
            if (cand[i] != ref_m[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic write_len(input int len);
        @(negedge clk);
        len_we = 1'b1; len_wdata = LEN_W'(len);
        @(negedge clk);
        len_we = 1'b0;
        if (len >= 1 && len <= MAX_LEN) ref_len_m = len;
    endtask

    task automatic load_ref(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ref_we = 1'b1; ref_addr = ADDR_W'(i); ref_wdata = ref_m[i];
        end
        @(negedge clk);
        ref_we = 1'b0;
        write_len(len);
    endtask

    // Sends n bytes (or one empty beat), checks flags and cycles to result.
    task automatic run_cmp(input int n, input bit empty_beat, input string tag,
                           output int lat);
        int beats;
        int w;
        bit em;
        beats = empty_beat ? 1 : n;
        em = empty_beat ? 1'b0 : exp_match(n);
        for (int b = 0; b < beats; b++) begin
            @(negedge clk);
            if (b > 0) check({tag, " R8 no early result"}, res_valid, 0);
            check({tag, " R2 ready"}, s_ready, 1);
            s_valid = 1'b1;
            s_data  = empty_beat ? 8'hA5 : cand[b];
            s_empty = empty_beat;
            s_last  = (b == beats - 1);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; s_empty = 1'b0;
        w = 1;
        while (!res_valid && w < 5) begin
            @(negedge clk);
            w++;
        end
        lat = beats + w;
        check({tag, " R3 R11 result one cycle after last"}, w, 1);
        check({tag, " R4 R5 match"}, res_match, em);
        check({tag, " R6 R7 len_err"}, res_len_err,
              (empty_beat || n != ref_len_m) ? 1 : 0);
        @(negedge clk);
        check({tag, " R3 single-cycle pulse"}, res_valid, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int lat_eq, lat_a, lat_b, len, n, mode, pos;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 ready in reset", s_ready, 0);
        check("R1 result in reset", res_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", s_ready, 1);

        // R10 reset reference: length 1, byte 0
        cand[0] = 8'h00;
        run_cmp(1, 1'b0, "R10 reset ref", lat_a);

        // Directed: 16-byte reference, timing independence
        for (int i = 0; i < MAX_LEN; i++) ref_m[i] = 8'($urandom);
        load_ref(16);
        for (int i = 0; i < 16; i++) cand[i] = ref_m[i];
        run_cmp(16, 1'b0, "R4 equal", lat_eq);
        cand[0] = ref_m[0] ^ 8'h01;
        run_cmp(16, 1'b0, "R5 first diff", lat_a);
        cand[0] = ref_m[0];
        cand[15] = ref_m[15] ^ 8'h80;
        run_cmp(16, 1'b0, "R5 last diff", lat_b);
        check("R11 latency first vs equal", lat_a, lat_eq);
        check("R11 latency last vs equal", lat_b, lat_eq);
        cand[15] = ref_m[15];
        run_cmp(15, 1'b0, "R6 short", lat_a);
        for (int i = 16; i < 20; i++) cand[i] = 8'($urandom);
        run_cmp(20, 1'b0, "R6 R8 long", lat_a);
        check("R8 long consumed at one per cycle", lat_a, 21);
        run_cmp(0, 1'b1, "R7 empty", lat_a);
        run_cmp(16, 1'b0, "R9 clean after failures", lat_a);

        // R10 out-of-range length writes are ignored
        write_len(0);
        run_cmp(16, 1'b0, "R10 len 0 ignored", lat_a);
        write_len(MAX_LEN + 1);
        run_cmp(16, 1'b0, "R10 len 65 ignored", lat_a);

        // Boundary lengths
        load_ref(1);
        cand[0] = ref_m[0];
        run_cmp(1, 1'b0, "R4 len 1", lat_a);
        load_ref(MAX_LEN);
        for (int i = 0; i < MAX_LEN; i++) cand[i] = ref_m[i];
        run_cmp(MAX_LEN, 1'b0, "R4 len 64", lat_a);
        cand[MAX_LEN - 1] = ~ref_m[MAX_LEN - 1];
        run_cmp(MAX_LEN, 1'b0, "R5 len 64 last diff", lat_a);

        // Constrained random
        for (int it = 0; it < 150; it++) begin
            if (it % 10 == 0) begin
                len = 1 + int'($urandom_range(MAX_LEN - 1));
                for (int i = 0; i < MAX_LEN; i++) ref_m[i] = 8'($urandom);
                load_ref(len);
            end
            mode = int'($urandom_range(3));
            n = ref_len_m;
            if (mode == 3) n = int'($urandom_range(MAX_LEN + 8));
            if (n == 0) n = 1;
            for (int i = 0; i < n; i++)
                cand[i] = (i < MAX_LEN) ? ref_m[i] : 8'($urandom);
            if (mode == 1) begin
                pos = int'($urandom_range(n - 1));
                cand[pos] = cand[pos] ^ (8'($urandom) | 8'h01);
            end
            run_cmp(n, 1'b0, "R4 R5 R6 random", lat_a);
            check("R11 random latency", lat_a, n + 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule